// File: doc/BRIEF.md
# Serial Flash Power-Up Readiness Sequencer

This host-side block brings a serial NOR flash out of power-up. Once the supply-good input goes high it starts a cycle counter and keeps the chip select released through a mandatory settling period. It then sends repeated one-byte register reads over single-line SPI until the returned byte reports that the device has finished initializing, and raises a ready flag that tells the rest of the host that normal flash access may begin.

Two busy indicators with opposite polarity can be polled: the status register, where bit 0 high means busy, and the flag register, where bit 7 high means ready. A limit select bounds the wait so that the longer internal recovery after an interrupted subsector erase can be covered. If polling is switched off, the block falls back to a blind fixed wait. Every delay is given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `flash_pu_sequencer`

## Requirements
- R1: While reset is high, spi_cs_n is 1, spi_sck is 0, and dev_ready and tmo_err are 0. From the first clock edge after pwr_good is sampled low, spi_cs_n is 1.
- R2: In polling mode, spi_cs_n does not fall until at least 100 us (ceil(CLK_HZ*100/1e6) clocks) after pwr_good rose.
- R3: Each poll is one SPI mode-0 frame of 16 spi_sck pulses while spi_cs_n is low. spi_sck is low when idle. An 8-bit opcode goes out MSB first on spi_mosi, changing while spi_sck is low. The 8 response bits are then taken MSB first from spi_miso on the rising edges of spi_sck.
- R4: The opcode is 0x05 when flag_sel is 0 (status register) and 0x70 when flag_sel is 1 (flag register).
- R5: With flag_sel=0, a response whose bit 0 is 0 makes dev_ready rise within 3 clocks of the end of that frame. A response whose bit 0 is 1 leads to another poll.
- R6: With flag_sel=1, a response whose bit 7 is 1 makes dev_ready rise. A response whose bit 7 is 0 leads to another poll.
- R7: Between two frames, spi_cs_n stays high for at least GAP_CLKS (4) clocks.
- R8: limit_sel selects the poll limit measured from the rise of pwr_good: 0 gives 300 us, 1 gives 4.5 ms, 2 and 3 give 36 ms. tmo_err is set at the end of the first busy frame that completes at or after the limit, and never before the limit.
- R9: Once set, tmo_err stays at 1 and no further frame starts until reset, whatever pwr_good does. dev_ready stays at 0 while tmo_err is set.
- R10: With poll_en=0, no frame is ever sent. dev_ready rises on the clock edge after exactly 300 us of clocks since pwr_good rose.
- R11: Once set, dev_ready stays at 1 while pwr_good stays high. A low pwr_good clears it on the next edge, and a new rise of pwr_good restarts the whole sequence.
- R12: Every delay in clocks is ceil(CLK_HZ*us/1e6). With CLK_HZ=1 MHz, one clock equals 1 us.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply reported good |
| poll_en | input | 1 | 1: poll the device, 0: blind fixed wait |
| flag_sel | input | 1 | 0: poll status register, 1: poll flag register |
| limit_sel | input | 2 | Poll limit: 0 = 300 us, 1 = 4.5 ms, 2/3 = 36 ms |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI serial clock (mode 0) |
| spi_mosi | output | 1 | Command line to the device |
| spi_miso | input | 1 | Response line from the device |
| dev_ready | output | 1 | Device may be accessed normally |
| tmo_err | output | 1 | Sticky poll-limit error |

## Verification
The bench acts as the flash. It decodes every frame, returns busy bytes whose other bits are deliberately set, and counts how many polls arrive before ready is raised. A design that read the wrong bit, the wrong polarity or the bits in reverse order would stop too early or would never stop. The limit tests sample tmo_err just before and just after 300 us, 4.5 ms and 36 ms, and use a fourth run under code 3 that must outlast 4.5 ms. A wrong limit mapping would flag an error early or would miss the error. Dropping the supply in the middle of a frame, toggling it after a timeout, and running the blind mode exactly at its 300-cycle edge catch a chip select that stays low, an error that does not stick or that keeps polling, and a fixed wait that is off by one.

// File: rtl/flash_pu_pkg.sv
`timescale 1ns/1ps
package flash_pu_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_LAUNCH,
        ST_XFER,
        ST_GAP,
        ST_READY,
        ST_TMO
    } pu_state_e;

    // response of one completed poll frame
    typedef struct packed {
        logic [7:0] data;
        logic       valid;
    } poll_rsp_t;

    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_RD_FLAGS  = 8'h70;

    localparam int PRE_POLL_US = 100;
    localparam int BLIND_US    = 300;
    localparam int LIM_A_US    = 300;
    localparam int LIM_B_US    = 4500;
    localparam int LIM_C_US    = 36000;

    // microseconds to clock cycles, rounded up
    function automatic int us_to_cycles(input int clk_hz, input int us);
        longint prod;
        prod = longint'(clk_hz) * longint'(us);
        return int'((prod + 64'd999999) / 64'd1000000);
    endfunction

    // opposite polarity of the two busy indicators
    function automatic logic says_ready(input logic use_flags, input logic [7:0] b);
        return use_flags ? b[7] : ~b[0];
    endfunction

endpackage

// File: rtl/flash_pu_timer.sv
`timescale 1ns/1ps
module flash_pu_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] elapsed
);
    // counts clocks since run rose; saturates at all ones
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            elapsed <= '0;
        end else if (elapsed != '1) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end
endmodule

// File: rtl/flash_pu_spi_engine.sv
`timescale 1ns/1ps
module flash_pu_spi_engine
    import flash_pu_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] opcode,
    input  logic       miso,
    output logic       cs_n,
    output logic       sck,
    output logic       mosi,
    output poll_rsp_t  rsp
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
    localparam logic [3:0] LAST_BIT = 4'd15;

    logic             active;
    logic [DIV_W-1:0] div;
    logic [3:0]       bitn;
    logic [7:0]       tx;
    logic [7:0]       rx;
    logic             rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cs_n      <= 1'b1;
            sck       <= 1'b0;
            mosi      <= 1'b0;
            div       <= '0;
            bitn      <= '0;
            tx        <= '0;
            rx        <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                cs_n   <= 1'b1;
                sck    <= 1'b0;
                mosi   <= 1'b0;
            end else if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cs_n   <= 1'b0;
                    sck    <= 1'b0;
                    div    <= '0;
                    bitn   <= '0;
                    mosi   <= opcode[7];
                    tx     <= {opcode[6:0], 1'b0};
                end
            end else if (div != DIV_LAST) begin
                div <= div + DIV_W'(1);
            end else begin
                div <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    if (bitn[3]) rx <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bitn == LAST_BIT) begin
                        active    <= 1'b0;
                        cs_n      <= 1'b1;
                        mosi      <= 1'b0;
                        rsp_valid <= 1'b1;
                    end else begin
                        bitn <= bitn + 4'd1;
                        mosi <= tx[7];
                        tx   <= {tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rsp = '{data: rx, valid: rsp_valid};
endmodule

// File: rtl/flash_pu_sequencer.sv
`timescale 1ns/1ps
module flash_pu_sequencer
    import flash_pu_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int SCK_HALF = 4,
    parameter int GAP_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       poll_en,
    input  logic       flag_sel,
    input  logic [1:0] limit_sel,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       dev_ready,
    output logic       tmo_err
);
    localparam int T_PRE   = us_to_cycles(CLK_HZ, PRE_POLL_US);
    localparam int T_BLIND = us_to_cycles(CLK_HZ, BLIND_US);
    localparam int T_LIM_A = us_to_cycles(CLK_HZ, LIM_A_US);
    localparam int T_LIM_B = us_to_cycles(CLK_HZ, LIM_B_US);
    localparam int T_LIM_C = us_to_cycles(CLK_HZ, LIM_C_US);
    localparam int CNT_W   = $clog2(T_LIM_C + 2);
    localparam int GAP_W   = $clog2(GAP_CLKS + 1);

    localparam logic [CNT_W-1:0] C_PRE   = CNT_W'(T_PRE);
    localparam logic [CNT_W-1:0] C_BLIND = CNT_W'(T_BLIND);
    localparam logic [CNT_W-1:0] C_LIM_A = CNT_W'(T_LIM_A);
    localparam logic [CNT_W-1:0] C_LIM_B = CNT_W'(T_LIM_B);
    localparam logic [CNT_W-1:0] C_LIM_C = CNT_W'(T_LIM_C);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CLKS - 1);

    pu_state_e        state, state_nx;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] limit;
    logic [GAP_W-1:0] gap_cnt;
    poll_rsp_t        rsp;
    logic [7:0]       opcode;

    flash_pu_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (pwr_good),
        .elapsed (elapsed)
    );

    assign opcode = flag_sel ? OP_RD_FLAGS : OP_RD_STATUS;

    flash_pu_spi_engine #(.HALF(SCK_HALF)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .start  (state == ST_LAUNCH),
        .abort  (!pwr_good),
        .opcode (opcode),
        .miso   (spi_miso),
        .cs_n   (spi_cs_n),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .rsp    (rsp)
    );

    always_comb begin
        case (limit_sel)
            2'd0:    limit = C_LIM_A;
            2'd1:    limit = C_LIM_B;
            default: limit = C_LIM_C;
        endcase
    end

    always_comb begin
        state_nx = state;
        if (state != ST_TMO && !pwr_good) begin
            state_nx = ST_OFF;
        end else begin
            case (state)
                ST_OFF:    state_nx = ST_SETTLE;
                ST_SETTLE: begin
                    if (!poll_en) begin
                        if (elapsed >= C_BLIND) state_nx = ST_READY;
                    end else if (elapsed >= C_PRE) begin
                        state_nx = ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state_nx = ST_XFER;
                ST_XFER: begin
                    if (rsp.valid) begin
                        if (says_ready(flag_sel, rsp.data)) state_nx = ST_READY;
                        else if (elapsed >= limit)          state_nx = ST_TMO;
                        else                                state_nx = ST_GAP;
                    end
                end
                ST_GAP:    if (gap_cnt == GAP_LAST) state_nx = ST_LAUNCH;
                default:   state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            gap_cnt <= '0;
        end else begin
            state   <= state_nx;
            gap_cnt <= (state == ST_GAP) ? gap_cnt + GAP_W'(1) : '0;
        end
    end

    assign dev_ready = (state == ST_READY);
    assign tmo_err   = (state == ST_TMO);
endmodule

// File: rtl/flash_pu_checker.sv
`timescale 1ns/1ps
module flash_pu_checker
    import flash_pu_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int GAP_CLKS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       pwr_good,
    input logic       poll_en,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       dev_ready,
    input logic       tmo_err
);
    localparam int PRE_CYC = us_to_cycles(CLK_HZ, PRE_POLL_US);

    int unsigned pg_cnt;
    int unsigned hi_cnt;

    // independent count of clocks since supply-good and of chip-select high time
    always_ff @(posedge clk) begin
        if (rst || !pwr_good) pg_cnt <= 0;
        else if (pg_cnt < PRE_CYC + 2) pg_cnt <= pg_cnt + 1;
        if (rst || !spi_cs_n) hi_cnt <= 0;
        else if (hi_cnt < GAP_CLKS + 2) hi_cnt <= hi_cnt + 1;
    end

    assert_cs_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> spi_cs_n);

    assert_prepoll_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> pg_cnt >= PRE_CYC);

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> hi_cnt >= GAP_CLKS);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        tmo_err |=> tmo_err);

    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(dev_ready && tmo_err));

    assert_blind_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!poll_en && spi_cs_n) |=> spi_cs_n);

    assert_ready_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (dev_ready && pwr_good) |=> dev_ready);
endmodule

bind flash_pu_sequencer flash_pu_checker #(
    .CLK_HZ   (CLK_HZ),
    .GAP_CLKS (GAP_CLKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .poll_en   (poll_en),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .dev_ready (dev_ready),
    .tmo_err   (tmo_err)
);

// File: tb/flash_pu_sequencer_tb.sv
`timescale 1ns/1ps
module flash_pu_sequencer_tb;
    localparam realtime CLK_P = 10.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0;
    logic poll_en = 1'b1;
    logic flag_sel = 1'b0;
    logic [1:0] limit_sel = 2'd1;
    logic spi_miso = 1'b0;
    logic spi_cs_n, spi_sck, spi_mosi, dev_ready, tmo_err;

    always #(CLK_P / 2) clk = ~clk;

    flash_pu_sequencer #(.CLK_HZ(1_000_000), .SCK_HALF(2), .GAP_CLKS(4)) u_dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .poll_en(poll_en),
        .flag_sel(flag_sel), .limit_sel(limit_sel), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .dev_ready(dev_ready), .tmo_err(tmo_err)
    );

    int n_checks = 0;
    int n_errs = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- flash model and scoreboard ----------------
    logic [7:0] exp_q[$];
    bit         free_on = 0;
    logic [7:0] free_op = 8'h00;
    int         busy_left = 0;
    int         frames = 0;
    int         nrise = 0;
    logic [7:0] op_cap = 8'h00;
    logic [7:0] resp = 8'h00;
    bit         await_first = 0;
    realtime    t_pg = 0, t_rise = 0, t_ready = 0;

    always @(negedge spi_cs_n) begin
        nrise  = 0;
        op_cap = 8'h00;
        spi_miso = 1'b0;
        if (flag_sel) resp = (busy_left > 0) ? 8'h7F : 8'h80;
        else          resp = (busy_left > 0) ? 8'h03 : 8'h02;
        if (await_first) begin
            await_first = 0;
            check(($realtime - t_pg) >= 100 * CLK_P, "R2 first poll delay (clk)",
                  longint'(($realtime - t_pg) / CLK_P), 100);
        end else begin
            check(($realtime - t_rise) >= 4 * CLK_P, "R7 chip-select gap (clk)",
                  longint'(($realtime - t_rise) / CLK_P), 4);
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (nrise < 8) op_cap = {op_cap[6:0], spi_mosi};
            nrise++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && nrise >= 8 && nrise < 16) spi_miso = resp[15 - nrise];
    end

    // monitor: pops expected opcodes as frames complete
    always @(posedge spi_cs_n) begin
        t_rise = $realtime;
        if (nrise == 16) begin
            frames++;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(op_cap == e, "R3 R4 opcode", op_cap, e);
            end else if (free_on) begin
                check(op_cap == free_op, "R3 R4 opcode", op_cap, free_op);
            end else begin
                check(0, "R9 R10 unexpected frame", frames, frames - 1);
            end
            if (busy_left > 0) busy_left--;
        end
        nrise = 0;
    end

    always @(posedge dev_ready) t_ready = $realtime;

    // ---------------- driver tasks ----------------
    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_polls(input int n, input logic [7:0] op);
        for (int i = 0; i < n; i++) exp_q.push_back(op);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pwr_good = 1'b0;
        free_on = 0;
        cycles(3);
        rst = 1'b0;
        cycles(1);
    endtask

    task automatic power_on();
        @(negedge clk);
        pwr_good = 1'b1;
        t_pg = $realtime;
        await_first = 1;
    endtask

    task automatic wait_ready(input int max);
        for (int i = 0; i < max && !dev_ready; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    endtask

    initial begin
        #(150_000 * CLK_P);
        if (!done_flag) begin
            n_errs++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        int snap;
        // R1: reset state
        cycles(2);
        check(spi_cs_n == 1'b1, "R1 cs_n in reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck in reset", spi_sck, 0);
        check(dev_ready == 1'b0, "R1 ready in reset", dev_ready, 0);
        check(tmo_err == 1'b0, "R1 err in reset", tmo_err, 0);
        rst = 1'b0;
        cycles(20);
        check(spi_cs_n == 1'b1, "R1 cs_n while supply low", spi_cs_n, 1);

        // R5: status polling, three busy then ready
        poll_en = 1; flag_sel = 0; limit_sel = 2'd1; busy_left = 3;
        push_polls(4, 8'h05);
        power_on();
        wait_ready(1000);
        check(dev_ready == 1'b1, "R5 status ready seen", dev_ready, 1);
        check(frames == 4, "R5 status poll count", frames, 4);
        check((t_ready - t_rise) <= 3 * CLK_P, "R5 ready latency (clk)",
              longint'((t_ready - t_rise) / CLK_P), 3);
        check(tmo_err == 1'b0, "R5 no error", tmo_err, 0);

        // R6: flag polling, two busy then ready
        do_reset();
        frames = 0; flag_sel = 1; busy_left = 2;
        push_polls(3, 8'h70);
        power_on();
        wait_ready(1000);
        check(dev_ready == 1'b1, "R6 flag ready seen", dev_ready, 1);
        check(frames == 3, "R6 flag poll count", frames, 3);

        // R11: hold, drop, restart
        cycles(200);
        check(dev_ready == 1'b1, "R11 ready held", dev_ready, 1);
        pwr_good = 1'b0;
        cycles(2);
        check(dev_ready == 1'b0, "R11 ready cleared by supply drop", dev_ready, 0);
        check(spi_cs_n == 1'b1, "R1 cs_n after drop", spi_cs_n, 1);
        cycles(5);
        flag_sel = 0; busy_left = 0;
        push_polls(1, 8'h05);
        power_on();
        wait_ready(1000);
        check(dev_ready == 1'b1 && frames == 4, "R11 restart after new supply rise", frames, 4);

        // R1: supply drop in the middle of a frame
        do_reset();
        frames = 0; busy_left = 1_000_000;
        power_on();
        cycles(120);
        check(spi_cs_n == 1'b0, "R2 frame in progress", spi_cs_n, 0);
        pwr_good = 1'b0;
        cycles(1);
        check(spi_cs_n == 1'b1, "R1 cs_n released on drop", spi_cs_n, 1);
        cycles(50);
        check(dev_ready == 1'b0 && tmo_err == 1'b0, "R1 idle after drop", dev_ready, 0);

        // R8/R9: 300 us limit, device always busy
        do_reset();
        frames = 0; busy_left = 1_000_000; limit_sel = 2'd0;
        free_on = 1; free_op = 8'h05;
        power_on();
        cycles(299);
        check(tmo_err == 1'b0, "R8 no error before 300us", tmo_err, 0);
        for (int i = 0; i < 200 && !tmo_err; i++) @(negedge clk);
        check(tmo_err == 1'b1, "R8 error after 300us", tmo_err, 1);
        check(frames == 3, "R8 frames before 300us limit", frames, 3);
        free_on = 0;
        snap = frames;
        cycles(300);
        check(frames == snap && tmo_err == 1'b1, "R9 no polling after error", frames, snap);
        pwr_good = 1'b0;
        cycles(10);
        pwr_good = 1'b1;
        cycles(300);
        check(tmo_err == 1'b1, "R9 error survives supply toggle", tmo_err, 1);
        check(dev_ready == 1'b0, "R9 ready stays low", dev_ready, 0);
        check(frames == snap, "R9 no frames after toggle", frames, snap);
        do_reset();
        check(tmo_err == 1'b0, "R9 reset clears error", tmo_err, 0);

        // R8: 4.5 ms limit with flag register
        frames = 0; busy_left = 1_000_000; limit_sel = 2'd1; flag_sel = 1;
        free_on = 1; free_op = 8'h70;
        power_on();
        cycles(4500);
        check(tmo_err == 1'b0, "R8 no error before 4.5ms", tmo_err, 0);
        cycles(80);
        check(tmo_err == 1'b1, "R8 error after 4.5ms", tmo_err, 1);

        // R8: 36 ms limit
        do_reset();
        frames = 0; busy_left = 1_000_000; limit_sel = 2'd2; flag_sel = 0;
        free_on = 1; free_op = 8'h05;
        power_on();
        cycles(36000);
        check(tmo_err == 1'b0, "R8 no error before 36ms", tmo_err, 0);
        cycles(80);
        check(tmo_err == 1'b1, "R8 error after 36ms", tmo_err, 1);

        // R8: code 3 also gives 36 ms; ready after about 5 ms of busy
        do_reset();
        frames = 0; busy_left = 70; limit_sel = 2'd3;
        push_polls(71, 8'h05);
        power_on();
        wait_ready(6000);
        check(dev_ready == 1'b1 && tmo_err == 1'b0, "R8 code 3 outlasts 4.5ms", dev_ready, 1);
        check(frames == 71, "R8 code 3 poll count", frames, 71);

        // R10/R12: blind fixed wait
        do_reset();
        frames = 0; poll_en = 0;
        power_on();
        cycles(300);
        check(dev_ready == 1'b0, "R10 R12 not ready at 300 clocks", dev_ready, 0);
        cycles(1);
        check(dev_ready == 1'b1, "R10 R12 ready at 301 clocks", dev_ready, 1);
        cycles(100);
        check(frames == 0 && spi_cs_n == 1'b1, "R10 no SPI traffic", frames, 0);

        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        done_flag = 1;
        report();
        $finish;
    end
endmodule